// File: doc/BRIEF.md
# Decoded Integer ALU

This block is a combinational integer arithmetic unit with its own small operation decoder. The main controller of a processor supplies a two-bit operation class and the six-bit function field of the current instruction. The decoder turns these into a three-bit operation select. The arithmetic unit then applies that select to two operands and returns the result and a flag that is set when the result is zero.

The operation class takes priority over the function field. Loads and stores need an address sum. Branch-equal needs a difference. For these classes the function field is ignored. Only register-to-register instructions look at the function field. In the select code, the upper bit turns on subtraction: it complements operand B and supplies the carry-in. Add and subtract therefore share one adder. Set-on-less-than uses the same difference to make a signed comparison.

The datapath width and the adder implementation are parameters. The decoded select is also brought out as a port, so the decode can be observed.

Top module: `alu_unit`

## Requirements
- R1: `op_sel` only ever takes one of five codes: 000 AND, 001 OR, 010 add, 110 subtract, 111 set-on-less-than.
- R2: When `op_class` is 00, `op_sel` is 010 (add) for every value of `func_code`.
- R3: When `op_class` is 01 or 11 (bit 0 set), `op_sel` is 110 (subtract) for every value of `func_code`.
- R4: When `op_class` is 10, `func_code[3:0]` selects the operation: 0000 add, 0010 subtract, 0100 AND, 0101 OR, 1010 set-on-less-than. `func_code[5:4]` has no effect.
- R5: When `op_class` is 10 and `func_code[3:0]` is any other value, `op_sel` is 010 (add).
- R6: AND and OR return the bitwise AND or OR of `a_in` and `b_in`.
- R7: Add returns `a_in + b_in` modulo 2^WIDTH.
- R8: Subtract returns `a_in - b_in` modulo 2^WIDTH. This is computed as A + ~B + 1.
- R9: Set-on-less-than returns 1 when `a_in` is less than `b_in` as two's-complement signed values, and 0 otherwise. All bits above bit 0 are zero.
- R10: `zero` is 1 exactly when every bit of `result` is 0.
- R11: The block has no clock and no stored state. Its outputs follow any input change without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | WIDTH | Operand A |
| b_in | input | WIDTH | Operand B |
| op_class | input | 2 | Operation class from the main controller |
| func_code | input | 6 | Function field of the instruction |
| result | output | WIDTH | Result of the operation |
| zero | output | 1 | Set when `result` is all zeros |
| op_sel | output | 3 | Decoded operation select |

## Verification
The hardest case to reach is a signed comparison in which the subtraction overflows. There the sign bit of the difference gives the wrong answer, and the result must be corrected by the overflow term. These cases appear only when the operands have opposite signs and sit near the extremes of the range, so stimulus chosen at random seldom produces them. The bench therefore runs a second instance, 4 bits wide with the ripple adder, and drives it with every pair of operands under every operation. Every overflow combination is covered that way. On the 32-bit instance, the bench applies a fixed set of extreme operand pairs. It also sweeps all 256 combinations of class and function code, so that every override and every default decode is exercised.

// File: rtl/alu_pkg.sv
package alu_pkg;
   localparam int SEL_W   = 3;
   localparam int CLASS_W = 2;
   localparam int FUNC_W  = 6;
   localparam int INV_BIT = 2;

   typedef enum logic [SEL_W-1:0] {
      OP_AND = 3'b000,
      OP_OR  = 3'b001,
      OP_ADD = 3'b010,
      OP_SUB = 3'b110,
      OP_SLT = 3'b111
   } op_sel_e;

   typedef enum logic [CLASS_W-1:0] {
      CL_MEM   = 2'b00,
      CL_BRANCH = 2'b01,
      CL_REG   = 2'b10,
      CL_ALT   = 2'b11
   } op_class_e;
endpackage

// File: rtl/alu_op_decoder.sv
module alu_op_decoder
   import alu_pkg::*;
(
   input  logic [CLASS_W-1:0] op_class,
   input  logic [FUNC_W-1:0]  func_code,
   output logic [SEL_W-1:0]   op_sel
);
   always_comb begin
      op_sel = OP_ADD;
      if (op_class[0]) begin
         op_sel = OP_SUB;
      end else if (op_class[1]) begin
         unique case (func_code[3:0])
            4'b0000: op_sel = OP_ADD;
            4'b0010: op_sel = OP_SUB;
            4'b0100: op_sel = OP_AND;
            4'b0101: op_sel = OP_OR;
            4'b1010: op_sel = OP_SLT;
            default: op_sel = OP_ADD;
         endcase
      end
   end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
   parameter int WIDTH  = 32,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   generate
      if (RIPPLE) begin : g_ripple
         always_comb begin
            logic c;
            c = cin;
            for (int i = 0; i < WIDTH; i++) begin
               sum[i] = a[i] ^ b[i] ^ c;
               c      = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
            end
            cout = c;
         end
      end else begin : g_behav
         logic [WIDTH:0] full;
         assign full = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
         assign sum  = full[WIDTH-1:0];
         assign cout = full[WIDTH];
      end
   endgenerate
endmodule

// File: rtl/alu_core.sv
module alu_core
   import alu_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [SEL_W-1:0] sel,
   output logic [WIDTH-1:0] y
);
   localparam int MSB = WIDTH - 1;

   logic             invert;
   logic [WIDTH-1:0] b_eff;
   logic [WIDTH-1:0] sum;
   logic             carry_out;
   logic             ovf;
   logic             less;

   assign invert = sel[INV_BIT];
   assign b_eff  = invert ? ~b : b;

   alu_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_add (
      .a    (a),
      .b    (b_eff),
      .cin  (invert),
      .sum  (sum),
      .cout (carry_out)
   );

   assign ovf  = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
   assign less = sum[MSB] ^ ovf;

   always_comb begin
      unique case (sel[1:0])
         2'b00:   y = a & b;
         2'b01:   y = a | b;
         2'b10:   y = sum;
         default: y = {{(WIDTH-1){1'b0}}, less};
      endcase
   end

   logic unused_carry;
   assign unused_carry = carry_out;
endmodule

// File: rtl/alu_unit.sv
module alu_unit
   import alu_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0]   a_in,
   input  logic [WIDTH-1:0]   b_in,
   input  logic [CLASS_W-1:0] op_class,
   input  logic [FUNC_W-1:0]  func_code,
   output logic [WIDTH-1:0]   result,
   output logic               zero,
   output logic [SEL_W-1:0]   op_sel
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu_unit: WIDTH must be at least 2");
      end
   endgenerate

   alu_op_decoder u_dec (
      .op_class  (op_class),
      .func_code (func_code),
      .op_sel    (op_sel)
   );

   alu_core #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_core (
      .a   (a_in),
      .b   (b_in),
      .sel (op_sel),
      .y   (result)
   );

   assign zero = ~|result;
endmodule

// File: rtl/alu_unit_chk.sv
module alu_unit_chk
   import alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input logic [WIDTH-1:0]   a_in,
   input logic [WIDTH-1:0]   b_in,
   input logic [CLASS_W-1:0] op_class,
   input logic [WIDTH-1:0]   result,
   input logic               zero,
   input logic [SEL_W-1:0]   op_sel
);
   always_comb begin
      assert_legal_sel_R1: assert (op_sel inside {3'b000, 3'b001, 3'b010, 3'b110, 3'b111})
         else $error("illegal op_sel %b", op_sel);
      if (op_class == 2'b00)
         assert_mem_add_R2: assert (op_sel == 3'b010)
            else $error("class 00 gave %b", op_sel);
      if (op_class[0])
         assert_branch_sub_R3: assert (op_sel == 3'b110)
            else $error("class x1 gave %b", op_sel);
      if (op_sel == 3'b000)
         assert_and_subset_R6: assert ((result & ~(a_in | b_in)) == '0 && (result & ~a_in) == '0)
            else $error("AND result outside operands");
      if (op_sel == 3'b111)
         assert_slt_upper_R9: assert (result[WIDTH-1:1] == '0)
            else $error("slt upper bits set");
      if (op_sel == 3'b110 && a_in == b_in)
         assert_equal_zero_R10: assert (zero)
            else $error("equal operands did not raise zero");
   end
endmodule

bind alu_unit alu_unit_chk #(.WIDTH(WIDTH)) u_chk (
   .a_in     (a_in),
   .b_in     (b_in),
   .op_class (op_class),
   .result   (result),
   .zero     (zero),
   .op_sel   (op_sel)
);

// File: tb/sim_alu_unit.sv
`timescale 1ns/1ps
module sim_alu_unit;
   localparam int W  = 32;
   localparam int WS = 4;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic [W-1:0]  a, b;
   logic [1:0]    cls;
   logic [5:0]    fn;
   logic [W-1:0]  res;
   logic          zr;
   logic [2:0]    sel;

   logic [WS-1:0] sa, sb;
   logic [1:0]    scls;
   logic [5:0]    sfn;
   logic [WS-1:0] sres;
   logic          szr;
   logic [2:0]    ssel;

   alu_unit #(.WIDTH(W), .RIPPLE(1'b0)) u0 (
      .a_in(a), .b_in(b), .op_class(cls), .func_code(fn),
      .result(res), .zero(zr), .op_sel(sel));

   alu_unit #(.WIDTH(WS), .RIPPLE(1'b1)) u1 (
      .a_in(sa), .b_in(sb), .op_class(scls), .func_code(sfn),
      .result(sres), .zero(szr), .op_sel(ssel));

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [2:0] exp_sel(input logic [1:0] c, input logic [5:0] f);
      if (c[0]) return 3'b110;
      if (c == 2'b00) return 3'b010;
      if (f[3:0] == 4'd0)  return 3'b010;
      if (f[3:0] == 4'd2)  return 3'b110;
      if (f[3:0] == 4'd4)  return 3'b000;
      if (f[3:0] == 4'd5)  return 3'b001;
      if (f[3:0] == 4'd10) return 3'b111;
      return 3'b010;
   endfunction

   function automatic longint sgn(input longint v, input int w);
      longint h;
      h = longint'(1) << (w - 1);
      return (v ^ h) - h;
   endfunction

   function automatic longint exp_res(input logic [2:0] s, input longint x, input longint y, input int w);
      longint m;
      m = (longint'(1) << w) - 1;
      case (s)
         3'b000:  return x & y;
         3'b001:  return x | y;
         3'b010:  return (x + y) & m;
         3'b110:  return (x - y) & m;
         default: return (sgn(x, w) < sgn(y, w)) ? 1 : 0;
      endcase
   endfunction

   function automatic string req_of(input logic [2:0] s);
      case (s)
         3'b000, 3'b001: return "R6";
         3'b010:         return "R7";
         3'b110:         return "R8";
         default:        return "R9";
      endcase
   endfunction

   // R-type function code for each operation
   function automatic logic [5:0] fn_of(input logic [2:0] s);
      case (s)
         3'b000:  return 6'b100100;
         3'b001:  return 6'b100101;
         3'b110:  return 6'b100010;
         3'b111:  return 6'b101010;
         default: return 6'b100000;
      endcase
   endfunction

   initial begin : watchdog
      int cyc;
      cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000 && !done) begin
            chk(1'b0, "watchdog", cyc, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
         end
      end
   end

   initial begin : stim
      logic [2:0] ops [5];
      longint pairs [12][2];
      ops = '{3'b000, 3'b001, 3'b010, 3'b110, 3'b111};
      pairs = '{'{0, 0}, '{1, 1}, '{32'hFFFF_FFFF, 1}, '{32'h7FFF_FFFF, 32'h8000_0000},
                '{32'h8000_0000, 32'h7FFF_FFFF}, '{32'h8000_0000, 1}, '{5, 7}, '{7, 5},
                '{32'hDEAD_BEEF, 32'h1234_5678}, '{32'hFFFF_FFFF, 32'hFFFF_FFFF},
                '{32'h0F0F_0F0F, 32'hF0F0_F0F0}, '{32'h7FFF_FFFF, 32'hFFFF_FFFF}};
      a = '0; b = '0; cls = 2'b00; fn = '0;
      sa = '0; sb = '0; scls = 2'b10; sfn = '0;
      #1;
      // R10 idle state: 0 + 0 gives zero result
      chk(res == 0 && zr == 1'b1 && sel == 3'b010, "R10 initial", {res, zr}, 1);

      // decode sweep: R2 R3 R4 R5 R1
      a = 32'd9; b = 32'd4;
      for (int c = 0; c < 4; c++) begin
         for (int f = 0; f < 64; f++) begin
            logic [2:0] e;
            cls = c[1:0]; fn = f[5:0];
            #1;
            e = exp_sel(cls, fn);
            chk(sel == e, c == 0 ? "R2" : (c[0] ? "R3" : "R4 R5"), sel, e);
            chk(res == exp_res(e, 9, 4, W), "R1 R4 result", res, exp_res(e, 9, 4, W));
         end
      end

      // 32-bit extreme operand pairs, every op through R-type decode
      cls = 2'b10;
      foreach (pairs[i]) begin
         for (int k = 0; k < 5; k++) begin
            longint e;
            a = pairs[i][0][W-1:0]; b = pairs[i][1][W-1:0]; fn = fn_of(ops[k]);
            #1;
            e = exp_res(ops[k], longint'(a), longint'(b), W);
            chk(res == e[W-1:0], req_of(ops[k]), res, e);
            chk(zr == (e == 0), "R10", zr, e == 0);
         end
      end

      // R11: change inputs with no clock edge involved
      @(negedge clk);
      a = 32'd3; b = 32'd3; fn = fn_of(3'b110);
      #0.5;
      chk(res == 0 && zr, "R11 sub settles", res, 0);
      a = 32'd10;
      #0.5;
      chk(res == 32'd7 && !zr, "R11 follows", res, 7);

      // exhaustive 4-bit ripple instance
      for (int k = 0; k < 5; k++) begin
         for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
               longint e;
               sa = x[WS-1:0]; sb = y[WS-1:0]; sfn = fn_of(ops[k]);
               #1;
               e = exp_res(ops[k], x, y, WS);
               chk(sres == e[WS-1:0] && ssel == ops[k], req_of(ops[k]), sres, e);
               chk(szr == (e == 0), "R10 small", szr, e == 0);
            end
         end
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule